// File: doc/BRIEF.md
# Hit-Only Address Readout for a Double-Column Pixel Region

This block drains one region of a binary hit matrix and sends out only the positions of pixels whose hit flag is set. The region is split into double columns, each holding its own flags. A hit arrives as a (double-column, pixel) pair and is stored as one flag bit. Each pixel has two flag banks. Incoming hits land in the capture bank, while the other bank is emptied toward the output. A frame-boundary pulse swaps the roles of the two banks.

Readout of a frame sends a start word that carries a frame number. Then the addresses of all set flags follow, one per clock when the consumer is ready. A closing word ends the frame. Inside a double column the lowest pixel address is sent first, and its flag is cleared at the moment the word is taken. Double columns are drained in ascending index order. Double columns with no hits take no cycles.

If a swap arrives before the previous frame has been fully sent, a sticky error flag is set. The unsent hits are then thrown away, so that every later frame still starts cleanly with its own start word.

Top module: `pixel_region_readout`

## Requirements
- R1: A synchronous active-high reset clears every flag in both banks, sets the frame number to 0 and clears `overflow`. While reset is held, `out_valid` is 0.
- R2: A data word has `out_kind` = 2, and `out_data` = {double-column index in bits [12:10], pixel address in bits [9:0]}. A data word is sent exactly once for each distinct pixel hit in the frame. Writing the same pixel twice gives one word. Pixels without a hit give no word.
- R3: Within a frame, data words come in ascending double-column index. Within one double column they come in ascending pixel address.
- R4: In the cycle after a swap, `out_valid` rises. From then on it stays high, and each cycle with `out_ready` high moves one word, until the closing word is taken. Empty double columns cost no idle cycles. A frame with N hits therefore needs N+2 accepted cycles.
- R5: The start word has `out_kind` = 1 and the closing word has `out_kind` = 3. Both carry the frame number in the low bits of `out_data`. The first frame after reset is number 0, and each swap adds one, wrapping at 8 bits.
- R6: A frame with no hits consists of its start word followed directly by its closing word.
- R7: While `out_valid` is high and `out_ready` is low, the word on the output is held unchanged and no flag is cleared.
- R8: Hits written while a frame is being sent go to the capture bank. They appear only in the next frame.
- R9: A swap while the previous frame is still being sent sets `overflow`, which stays set until reset. The remaining hits of that frame are discarded, and the new frame starts with its start word.
- R10: A hit written in the same cycle as a swap belongs to the frame that the swap closes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Readout clock |
| rst | input | 1 | Synchronous active-high reset |
| hit_valid | input | 1 | Store a hit into the capture bank this cycle |
| hit_dcol | input | 3 | Double-column index of the hit |
| hit_pix | input | 10 | Pixel address of the hit within its double column |
| frame_swap | input | 1 | Frame boundary: swap capture and readout banks |
| out_ready | input | 1 | Consumer accepts the current word |
| out_valid | output | 1 | A word is presented |
| out_kind | output | 2 | 1 start, 2 data, 3 closing |
| out_data | output | 13 | Address word or frame number |
| overflow | output | 1 | Sticky: a swap came before the frame was fully sent |

## Verification
The bench goes after several corner cases:
- Duplicate hits to one pixel: a design that counted hits instead of flags would send the address twice.
- A hit written in the same cycle as the swap: if the write were steered to the wrong bank, the address would show up one frame late.
- Back-pressure held for several cycles: a flag cleared without a handshake would lose an address.
- Drains with sparse double columns and full back-pressure off: a bubble per skipped column would break the N+2 cycle count.
- A swap in the middle of a frame: a design that did not discard hits would leak old addresses into the next frame and break the start-word alignment.

// File: rtl/pxr_pkg.sv
package pxr_pkg;

    // Output word classes; the numeric codes are visible on out_kind.
    typedef enum logic [1:0] {
        WK_IDLE = 2'd0,
        WK_SOF  = 2'd1,
        WK_DATA = 2'd2,
        WK_EOF  = 2'd3
    } word_kind_e;

    // Region sequencer states.
    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_HEAD = 2'd1,
        SQ_BODY = 2'd2
    } seq_state_e;

    // Per-double-column bank control produced by the sequencer.
    typedef struct packed {
        logic wr_bank;    // bank receiving new hits
        logic wipe;       // clear the bank leaving readout
        logic wipe_bank;
        logic pop;        // clear the pixel just accepted
    } bank_ctl_t;

    function automatic int unsigned idx_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/pxr_dcol_store.sv
module pxr_dcol_store
    import pxr_pkg::*;
#(
    parameter int unsigned PIX_PER_DCOL = 64,
    parameter int unsigned PIX_AW       = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [PIX_AW-1:0] wr_pix,
    input  bank_ctl_t         ctl,
    input  logic              pop_here,
    output logic              nonempty,
    output logic [PIX_AW-1:0] first_pix
);
    localparam int unsigned IW = idx_width(PIX_PER_DCOL);

    logic [PIX_PER_DCOL-1:0] bank_q [2];
    logic [PIX_PER_DCOL-1:0] bank_d [2];
    logic [PIX_PER_DCOL-1:0] rd_vec;
    logic [IW-1:0]           first_idx;
    logic [IW-1:0]           wr_idx;
    logic                    wr_in_range;
    logic                    rd_bank;

    assign rd_bank     = ~ctl.wr_bank;
    assign rd_vec      = bank_q[rd_bank];
    assign wr_idx      = wr_pix[IW-1:0];
    assign wr_in_range = (32'(wr_pix) < PIX_PER_DCOL);

    // Lowest set flag wins.
    always_comb begin
        first_idx = '0;
        for (int i = PIX_PER_DCOL - 1; i >= 0; i--) begin
            if (rd_vec[i]) first_idx = IW'(i);
        end
    end

    assign nonempty  = |rd_vec;
    assign first_pix = PIX_AW'(first_idx);

    always_comb begin
        for (int b = 0; b < 2; b++) begin
            bank_d[b] = bank_q[b];
            if (ctl.wipe && (ctl.wipe_bank == 1'(b)))
                bank_d[b] = '0;
            if (pop_here && (rd_bank == 1'(b)))
                bank_d[b][first_idx] = 1'b0;
            if (wr_en && wr_in_range && (ctl.wr_bank == 1'(b)))
                bank_d[b][wr_idx] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bank_q[0] <= '0;
            bank_q[1] <= '0;
        end else begin
            bank_q[0] <= bank_d[0];
            bank_q[1] <= bank_d[1];
        end
    end

endmodule

// File: rtl/pxr_dcol_select.sv
module pxr_dcol_select
    import pxr_pkg::*;
#(
    parameter int unsigned NUM_DCOL = 8,
    parameter int unsigned PIX_AW   = 10,
    parameter int unsigned DCOL_W   = 3
) (
    input  logic [NUM_DCOL-1:0] nonempty,
    input  logic [PIX_AW-1:0]   pix_in [NUM_DCOL],
    output logic                any_hit,
    output logic [DCOL_W-1:0]   sel_idx,
    output logic [PIX_AW-1:0]   sel_pix,
    output logic [NUM_DCOL-1:0] sel_onehot
);
    // Lowest-index non-empty double column is served; since the read bank
    // only loses flags, this walks the columns in ascending order without
    // ever visiting an empty one.
    always_comb begin
        sel_idx = '0;
        for (int i = NUM_DCOL - 1; i >= 0; i--) begin
            if (nonempty[i]) sel_idx = DCOL_W'(i);
        end
    end

    assign any_hit = |nonempty;

    always_comb begin
        sel_onehot = '0;
        sel_pix    = '0;
        for (int i = 0; i < NUM_DCOL; i++) begin
            if (any_hit && (sel_idx == DCOL_W'(i))) begin
                sel_onehot[i] = 1'b1;
                sel_pix       = pix_in[i];
            end
        end
    end

endmodule

// File: rtl/pxr_frame_seq.sv
module pxr_frame_seq
    import pxr_pkg::*;
#(
    parameter int unsigned FCNT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_swap,
    input  logic              any_hit,
    input  logic              out_ready,
    output logic              out_valid,
    output word_kind_e        kind,
    output logic [FCNT_W-1:0] frame_no,
    output logic              overflow,
    output bank_ctl_t         ctl
);
    seq_state_e        state_q;
    logic [FCNT_W-1:0] fcnt_q;
    logic [FCNT_W-1:0] hdr_q;
    logic              wr_bank_q;
    logic              ovf_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= SQ_IDLE;
            fcnt_q    <= '0;
            hdr_q     <= '0;
            wr_bank_q <= 1'b0;
            ovf_q     <= 1'b0;
        end else if (frame_swap) begin
            wr_bank_q <= ~wr_bank_q;
            hdr_q     <= fcnt_q;
            fcnt_q    <= fcnt_q + 1'b1;
            state_q   <= SQ_HEAD;
            if (state_q != SQ_IDLE) ovf_q <= 1'b1;
        end else begin
            case (state_q)
                SQ_HEAD: if (out_ready) state_q <= SQ_BODY;
                SQ_BODY: if (out_ready && !any_hit) state_q <= SQ_IDLE;
                default: state_q <= state_q;
            endcase
        end
    end

    always_comb begin
        case (state_q)
            SQ_HEAD: kind = WK_SOF;
            SQ_BODY: kind = any_hit ? WK_DATA : WK_EOF;
            default: kind = WK_IDLE;
        endcase
    end

    assign out_valid     = (state_q != SQ_IDLE);
    assign frame_no      = hdr_q;
    assign overflow      = ovf_q;
    assign ctl.wr_bank   = wr_bank_q;
    assign ctl.wipe      = frame_swap;
    assign ctl.wipe_bank = ~wr_bank_q;
    assign ctl.pop       = (state_q == SQ_BODY) && any_hit && out_ready && !frame_swap;

endmodule

// File: rtl/pixel_region_readout.sv
module pixel_region_readout
    import pxr_pkg::*;
#(
    parameter int unsigned NUM_DCOL     = 8,
    parameter int unsigned PIX_PER_DCOL = 64,
    parameter int unsigned PIX_AW       = 10,
    parameter int unsigned FCNT_W       = 8
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 hit_valid,
    input  logic [idx_width(NUM_DCOL)-1:0]       hit_dcol,
    input  logic [PIX_AW-1:0]                    hit_pix,
    input  logic                                 frame_swap,
    input  logic                                 out_ready,
    output logic                                 out_valid,
    output logic [1:0]                           out_kind,
    output logic [idx_width(NUM_DCOL)+PIX_AW-1:0] out_data,
    output logic                                 overflow
);
    localparam int unsigned DCOL_W = idx_width(NUM_DCOL);
    localparam int unsigned WORD_W = DCOL_W + PIX_AW;

    bank_ctl_t         ctl;
    word_kind_e        kind;
    logic [FCNT_W-1:0] frame_no;
    logic              any_hit;
    logic [NUM_DCOL-1:0] nonempty;
    logic [NUM_DCOL-1:0] sel_onehot;
    logic [PIX_AW-1:0]   first_pix [NUM_DCOL];
    logic [DCOL_W-1:0]   sel_idx;
    logic [PIX_AW-1:0]   sel_pix;

    generate
        for (genvar g = 0; g < NUM_DCOL; g++) begin : g_dcol
            pxr_dcol_store #(
                .PIX_PER_DCOL(PIX_PER_DCOL),
                .PIX_AW      (PIX_AW)
            ) u_store (
                .clk      (clk),
                .rst      (rst),
                .wr_en    (hit_valid && (hit_dcol == DCOL_W'(g))),
                .wr_pix   (hit_pix),
                .ctl      (ctl),
                .pop_here (ctl.pop && sel_onehot[g]),
                .nonempty (nonempty[g]),
                .first_pix(first_pix[g])
            );
        end
    endgenerate

    pxr_dcol_select #(
        .NUM_DCOL(NUM_DCOL),
        .PIX_AW  (PIX_AW),
        .DCOL_W  (DCOL_W)
    ) u_select (
        .nonempty  (nonempty),
        .pix_in    (first_pix),
        .any_hit   (any_hit),
        .sel_idx   (sel_idx),
        .sel_pix   (sel_pix),
        .sel_onehot(sel_onehot)
    );

    pxr_frame_seq #(
        .FCNT_W(FCNT_W)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .frame_swap(frame_swap),
        .any_hit   (any_hit),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .kind      (kind),
        .frame_no  (frame_no),
        .overflow  (overflow),
        .ctl       (ctl)
    );

    assign out_kind = kind;
    assign out_data = (kind == WK_DATA) ? {sel_idx, sel_pix} : WORD_W'(frame_no);

endmodule

// File: rtl/pixel_region_readout_chk.sv
module pixel_region_readout_chk #(
    parameter int unsigned WORD_W = 13
) (
    input logic              clk,
    input logic              rst,
    input logic              frame_swap,
    input logic              out_ready,
    input logic              out_valid,
    input logic [1:0]        out_kind,
    input logic [WORD_W-1:0] out_data,
    input logic              overflow
);
    // R1: reset leaves the output quiet and the error flag clear
    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!out_valid && !overflow));

    // R4: no bubble between an accepted non-closing word and the next word
    p_no_bubble_r4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_kind != 2'd3 && !frame_swap) |=> out_valid);

    // R5: a swap is followed by a start word
    p_sof_after_swap_r5: assert property (@(posedge clk) disable iff (rst)
        frame_swap |=> (out_valid && out_kind == 2'd1));

    // R6: an accepted closing word ends the frame
    p_eof_ends_r6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_kind == 2'd3 && !frame_swap) |=> !out_valid);

    // R7: back-pressure holds the presented word
    p_hold_word_r7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready && !frame_swap) |=>
            (out_valid && $stable(out_kind) && $stable(out_data)));

    // R9: the error flag is sticky
    p_overflow_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);

    // R9: the error flag only rises right after a swap
    p_overflow_cause_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(overflow) |-> $past(frame_swap));

endmodule

bind pixel_region_readout pixel_region_readout_chk #(.WORD_W(WORD_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .frame_swap(frame_swap),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_kind  (out_kind),
    .out_data  (out_data),
    .overflow  (overflow)
);

// File: tb/pixel_region_readout_bench.sv
`timescale 1ns/1ps
module pixel_region_readout_bench;
    localparam int ND = 8;
    localparam int NP = 64;
    localparam int DW = 3;
    localparam int PW = 10;
    localparam int WW = DW + PW;
    localparam logic [1:0] K_SOF = 2'd1, K_DAT = 2'd2, K_EOF = 2'd3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic hit_valid = 1'b0;
    logic [DW-1:0] hit_dcol = '0;
    logic [PW-1:0] hit_pix = '0;
    logic frame_swap = 1'b0;
    logic out_ready = 1'b0;
    logic out_valid;
    logic [1:0] out_kind;
    logic [WW-1:0] out_data;
    logic overflow;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [NP-1:0] cap [ND];
    logic [WW+1:0] q [$];
    logic [7:0] fcnt = 8'd0;
    logic exp_ovf = 1'b0;

    always #4 clk = ~clk;

    pixel_region_readout u_pixel_region_readout (
        .clk(clk), .rst(rst), .hit_valid(hit_valid), .hit_dcol(hit_dcol),
        .hit_pix(hit_pix), .frame_swap(frame_swap), .out_ready(out_ready),
        .out_valid(out_valid), .out_kind(out_kind), .out_data(out_data),
        .overflow(overflow)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic void model_clear();
        for (int d = 0; d < ND; d++) cap[d] = '0;
    endfunction

    // Expected word list of the frame being closed.
    function automatic void model_close_frame();
        q.push_back({K_SOF, WW'(fcnt)});
        for (int d = 0; d < ND; d++)
            for (int p = 0; p < NP; p++)
                if (cap[d][p]) q.push_back({K_DAT, DW'(d), PW'(p)});
        q.push_back({K_EOF, WW'(fcnt)});
        fcnt = fcnt + 8'd1;
        model_clear();
    endfunction

    task automatic step(input bit wv, input int d, input int p, input bit sw, input bit rdy);
        int pre;
        @(negedge clk);
        hit_valid = wv; hit_dcol = DW'(d); hit_pix = PW'(p);
        frame_swap = sw; out_ready = rdy;
        #1;
        pre = q.size();
        // R4: output present exactly while words are owed
        check(out_valid == (pre > 0), "R4 valid", int'(out_valid), int'(pre > 0));
        if (out_valid && pre > 0) begin
            // R2 R3 R5 R7: word matches the next expected word (held under back-pressure)
            check({out_kind, out_data} == q[0], "R2 R3 R5 R7 word",
                  int'({out_kind, out_data}), int'(q[0]));
            if (rdy) void'(q.pop_front());
        end
        check(overflow == exp_ovf, "R9 overflow", int'(overflow), int'(exp_ovf));
        if (wv) cap[d][p] = 1'b1;       // R10: same-cycle write joins the closing frame
        if (sw) begin
            if (pre > 0) begin
                q.delete();
                exp_ovf = 1'b1;
            end
            model_close_frame();
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; hit_valid = 1'b0; frame_swap = 1'b0; out_ready = 1'b0;
        repeat (2) @(negedge clk);
        #1;
        // R1: quiet and clear while held in reset
        check(out_valid == 1'b0, "R1 valid in reset", int'(out_valid), 0);
        check(overflow == 1'b0, "R1 overflow in reset", int'(overflow), 0);
        rst = 1'b0;
        model_clear(); q.delete(); fcnt = 8'd0; exp_ovf = 1'b0;
    endtask

    task automatic drain(input bit rand_ready, output int steps);
        steps = 0;
        while (q.size() > 0 && steps < 5000) begin
            step(0, 0, 0, 0, rand_ready ? (($urandom % 4) != 0) : 1'b1);
            steps++;
        end
    endtask

    initial begin
        int n;
        int words;
        void'($urandom(32'd20240611));
        do_reset();

        // R6 R5: empty region gives start and closing words, frame number 0
        step(0, 0, 0, 1, 1);
        check(q.size() == 2, "R6 empty frame length", q.size(), 2);
        drain(0, n);

        // R2 R3: scattered hits, out of order and duplicated
        step(1, 3, 63, 0, 1);
        step(1, 0, 5, 0, 1);
        step(1, 0, 3, 0, 1);
        step(1, 7, 0, 0, 1);
        step(1, 0, 5, 0, 1);
        // R10: hit written in the swap cycle
        step(1, 5, 9, 1, 1);
        words = q.size();
        check(words == 7, "R2 R10 word count", words, 7);
        // R4: full-rate drain takes one cycle per word
        drain(0, n);
        check(n == words, "R4 drain cycles", n, words);

        // R7: long back-pressure on a fresh frame
        step(1, 2, 1, 0, 1);
        step(1, 6, 40, 0, 1);
        step(1, 1, 17, 1, 1);
        repeat (6) step(0, 0, 0, 0, 0);
        drain(1, n);

        // R8: random frames, hits written while the previous frame drains
        for (int f = 0; f < 40; f++) begin
            int nh = $urandom_range(0, 40);
            int wr = 0;
            while (wr < nh || q.size() > 0) begin
                bit wv = (wr < nh) && ($urandom % 2 == 1);
                step(wv, $urandom_range(0, ND - 1), $urandom_range(0, NP - 1), 0,
                     ($urandom % 4) != 0);
                if (wv) wr++;
            end
            step($urandom % 2 == 1, $urandom_range(0, ND - 1), $urandom_range(0, NP - 1), 1, 1);
        end
        drain(1, n);
        check(overflow == 1'b0, "R9 no overflow on clean frames", int'(overflow), 0);

        // R9: swap before drain completes
        step(1, 4, 10, 0, 1);
        step(1, 4, 11, 1, 1);
        repeat (3) step(0, 0, 0, 0, 0);
        step(1, 2, 7, 0, 0);
        step(0, 0, 0, 1, 0);
        drain(0, n);
        repeat (3) step(0, 0, 0, 0, 1);
        check(overflow == 1'b1, "R9 overflow sticky", int'(overflow), 1);

        // R1: reset discards captured hits and restarts numbering
        step(1, 6, 6, 0, 1);
        step(1, 0, 0, 0, 1);
        do_reset();
        step(0, 0, 0, 1, 1);
        check(q.size() == 2, "R1 empty after reset", q.size(), 2);
        drain(0, n);
        step(0, 0, 0, 0, 1);
        check(q.size() == 0, "R6 all words delivered", q.size(), 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule